// File: doc/BRIEF.md
# Real-Mode Stack Transfer Sequencer

This block carries out the stack side of 16-bit control transfers in real mode: near call, far call, near return, far return and interrupt return. A control unit presents the operation and the current machine state (return IP, CS, stack pointer, stack-size bit, a pop adjustment, a branch target and the CS limit) together with a one-cycle `start`. The sequencer then walks the word-wide stack memory port one access at a time, waiting for `mem_rdy` on each, and finishes with a one-cycle `done` carrying the new IP, CS, CS base, stack pointer and, for interrupt return, the FLAGS word.

The stack pointer moves on a private copy while the operation runs. If the resulting IP lies above the CS limit, `fault` is raised with `done` and the state outputs carry the values the operation started from. Memory words already written by a push stay written.

Operation codes on `op`: 0 near call, 1 far call, 2 near return, 3 far return, 4 interrupt return. Codes 5 to 7 are not operations.

Top module: `rm_stack_seq`

## Requirements
- R1: Near call (op 0) writes `ip_in` as one word at address SP-2, then reports IP = `tgt_ip`, CS and CS base unchanged, stack pointer SP-2.
- R2: Far call (op 1) writes `cs_in` at SP-2 and then `ip_in` at SP-4; it reports IP = `tgt_ip`, CS = `tgt_cs` and CS base = `tgt_cs` × 16 (20 bits).
- R3: Near return (op 2) reads IP from SP; far return (op 3) reads IP from SP and then CS from SP+2; each read advances the pointer by 2, and a far return sets CS base = CS × 16.
- R4: Interrupt return (op 4) reads IP, CS and FLAGS from SP, SP+2, SP+4 in that order; on success `flags_out` carries the FLAGS word with a one-cycle `flags_wr`; `nmi_unblock` pulses with `done` on every interrupt return, faulted or not.
- R5: For near and far return, `imm_adj` (zero-extended) is added after the pops to the full 32-bit pointer when `stk32`=1, or to the low 16 bits only with wrap-around (upper half kept) when `stk32`=0; calls and interrupt return ignore `imm_adj`.
- R6: With `stk32`=0 every pointer step wraps within the low 16 bits, the upper 16 bits are kept, and `mem_addr` is the zero-extended low half; with `stk32`=1 all 32 bits move and address memory.
- R7: If the new IP is greater (unsigned) than `cs_limit`, `done` comes with `fault`=1 and IP, CS, CS base and stack pointer outputs show the starting values, with no `flags_wr`; an IP equal to the limit does not fault.
- R8: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_rdy`; accesses are issued one at a time.
- R9: `done` is a single-cycle pulse once per operation, with `mem_req` low; `start` while an operation is in progress, or with op 5 to 7, is ignored.
- R10: After reset the block is idle with `mem_req`, `done`, `fault`, `flags_wr`, `nmi_unblock` low and all state outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| ip_in | input | 16 | Return IP / current IP |
| cs_in | input | 16 | Current code selector |
| sp_in | input | 32 | Current stack pointer |
| stk32 | input | 1 | 1: 32-bit stack pointer, 0: 16-bit |
| imm_adj | input | 16 | Pop adjustment for returns |
| tgt_ip | input | 16 | Branch target offset for calls |
| tgt_cs | input | 16 | Branch target selector for far call |
| cs_limit | input | 16 | Code segment limit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Stack word address |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read |
| mem_rdy | input | 1 | Access complete |
| ip_out | output | 16 | Resulting IP |
| cs_out | output | 16 | Resulting CS selector |
| cs_base | output | 20 | Resulting CS base |
| sp_out | output | 32 | Resulting stack pointer |
| flags_out | output | 16 | FLAGS word popped by interrupt return |
| flags_wr | output | 1 | `flags_out` is to be written |
| nmi_unblock | output | 1 | Clear the NMI-blocked state |
| done | output | 1 | Operation finished |
| fault | output | 1 | General-protection fault (with `done`) |

## Verification
The assertions take for granted that `mem_rdy` is only raised while a request is pending and only for one cycle per access, so a request that is not yet acknowledged must hold its address and data. The bench's memory responder samples `mem_req` away from the clock edge and answers it after a per-operation latency of zero to two cycles, never raising `mem_rdy` for an idle port. Operation inputs are held only around `start`, which is safe because the block latches them, and one case deliberately changes them and pulses `start` mid-operation.

// File: rtl/rm_seq_pkg.sv
package rm_seq_pkg;

  typedef enum logic [2:0] {
    OP_NCALL = 3'd0,
    OP_FCALL = 3'd1,
    OP_NRET  = 3'd2,
    OP_FRET  = 3'd3,
    OP_IRET  = 3'd4
  } xfer_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_FIN
  } seq_st_e;

  // Number of stack words moved by each operation.
  function automatic logic [1:0] words_of(input xfer_op_e o);
    case (o)
      OP_FCALL, OP_FRET: words_of = 2'd2;
      OP_IRET:           words_of = 2'd3;
      default:           words_of = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/rm_sp_step.sv
// Stack pointer step: full-width when wide, low half only otherwise.
module rm_sp_step #(
  parameter int WORD = 16,
  parameter int SPW  = 32
) (
  input  logic [SPW-1:0] sp,
  input  logic           wide,
  input  logic           sub,
  input  logic [SPW-1:0] delta,
  output logic [SPW-1:0] sp_next
);
  logic [SPW-1:0]  full;
  logic [WORD-1:0] low;

  always_comb begin
    full = sub ? (sp - delta) : (sp + delta);
    low  = sub ? (sp[WORD-1:0] - delta[WORD-1:0]) : (sp[WORD-1:0] + delta[WORD-1:0]);
    sp_next = wide ? full : {sp[SPW-1:WORD], low};
  end
endmodule

// File: rtl/rm_ip_gate.sv
// Limit check for the new IP and real-mode base of the new selector.
module rm_ip_gate #(
  parameter int WORD = 16
) (
  input  logic [WORD-1:0] new_ip,
  input  logic [WORD-1:0] limit,
  input  logic [WORD-1:0] sel,
  output logic            over,
  output logic [WORD+3:0] base
);
  assign over = (new_ip > limit);
  assign base = {sel, 4'b0000};
endmodule

// File: rtl/rm_stack_seq.sv
module rm_stack_seq
  import rm_seq_pkg::*;
#(
  parameter int WORD = 16,
  parameter int SPW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [WORD-1:0] ip_in,
  input  logic [WORD-1:0] cs_in,
  input  logic [SPW-1:0]  sp_in,
  input  logic            stk32,
  input  logic [WORD-1:0] imm_adj,
  input  logic [WORD-1:0] tgt_ip,
  input  logic [WORD-1:0] tgt_cs,
  input  logic [WORD-1:0] cs_limit,
  output logic            mem_req,
  output logic            mem_we,
  output logic [SPW-1:0]  mem_addr,
  output logic [WORD-1:0] mem_wdata,
  input  logic [WORD-1:0] mem_rdata,
  input  logic            mem_rdy,
  output logic [WORD-1:0] ip_out,
  output logic [WORD-1:0] cs_out,
  output logic [WORD+3:0] cs_base,
  output logic [SPW-1:0]  sp_out,
  output logic [WORD-1:0] flags_out,
  output logic            flags_wr,
  output logic            nmi_unblock,
  output logic            done,
  output logic            fault
);
  localparam int STEP  = WORD / 8;
  localparam int HI    = SPW - WORD;
  localparam int MAXOP = 4;

  seq_st_e         st_q;
  xfer_op_e        op_q;
  logic            big_q;
  logic [WORD-1:0] ip_q, cs_q, imm_q, tip_q, tcs_q, lim_q;
  logic [SPW-1:0]  sp_orig_q, sp_spec_q;
  logic [1:0]      idx_q;
  logic [WORD-1:0] pop_ip_q, pop_cs_q, pop_fl_q;

  logic            is_call, is_ret_imm, last_word;
  logic [SPW-1:0]  sp_dec, sp_inc, sp_adj, acc_sp;
  logic [WORD-1:0] new_ip, new_cs;
  logic            ip_over;
  logic [WORD+3:0] new_base, orig_base;
  logic            orig_over;

  assign is_call    = (op_q == OP_NCALL) || (op_q == OP_FCALL);
  assign is_ret_imm = (op_q == OP_NRET)  || (op_q == OP_FRET);
  assign last_word  = (idx_q == words_of(op_q) - 2'd1);

  rm_sp_step #(.WORD(WORD), .SPW(SPW)) u_dec (
    .sp(sp_spec_q), .wide(big_q), .sub(1'b1),
    .delta(SPW'(STEP)), .sp_next(sp_dec)
  );
  rm_sp_step #(.WORD(WORD), .SPW(SPW)) u_inc (
    .sp(sp_spec_q), .wide(big_q), .sub(1'b0),
    .delta(SPW'(STEP)), .sp_next(sp_inc)
  );
  rm_sp_step #(.WORD(WORD), .SPW(SPW)) u_adj (
    .sp(sp_spec_q), .wide(big_q), .sub(1'b0),
    .delta({{HI{1'b0}}, imm_q}), .sp_next(sp_adj)
  );

  // Push writes below the pointer; pop reads at it.
  assign acc_sp    = is_call ? sp_dec : sp_spec_q;
  assign mem_req   = (st_q == ST_ACC);
  assign mem_we    = is_call;
  assign mem_addr  = big_q ? acc_sp : {{HI{1'b0}}, acc_sp[WORD-1:0]};
  assign mem_wdata = ((op_q == OP_FCALL) && (idx_q == 2'd0)) ? cs_q : ip_q;

  always_comb begin
    new_ip = is_call ? tip_q : pop_ip_q;
    case (op_q)
      OP_FCALL:         new_cs = tcs_q;
      OP_FRET, OP_IRET: new_cs = pop_cs_q;
      default:          new_cs = cs_q;
    endcase
  end

  rm_ip_gate #(.WORD(WORD)) u_gate (
    .new_ip(new_ip), .limit(lim_q), .sel(new_cs),
    .over(ip_over), .base(new_base)
  );
  rm_ip_gate #(.WORD(WORD)) u_orig (
    .new_ip(ip_q), .limit(lim_q), .sel(cs_q),
    .over(orig_over), .base(orig_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_NCALL;
      big_q       <= 1'b0;
      ip_q        <= '0;
      cs_q        <= '0;
      imm_q       <= '0;
      tip_q       <= '0;
      tcs_q       <= '0;
      lim_q       <= '0;
      sp_orig_q   <= '0;
      sp_spec_q   <= '0;
      idx_q       <= '0;
      pop_ip_q    <= '0;
      pop_cs_q    <= '0;
      pop_fl_q    <= '0;
      ip_out      <= '0;
      cs_out      <= '0;
      cs_base     <= '0;
      sp_out      <= '0;
      flags_out   <= '0;
      flags_wr    <= 1'b0;
      nmi_unblock <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
    end else begin
      done        <= 1'b0;
      fault       <= 1'b0;
      flags_wr    <= 1'b0;
      nmi_unblock <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start && (int'(op) <= MAXOP)) begin
            op_q      <= xfer_op_e'(op);
            big_q     <= stk32;
            ip_q      <= ip_in;
            cs_q      <= cs_in;
            imm_q     <= imm_adj;
            tip_q     <= tgt_ip;
            tcs_q     <= tgt_cs;
            lim_q     <= cs_limit;
            sp_orig_q <= sp_in;
            sp_spec_q <= sp_in;
            idx_q     <= '0;
            st_q      <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (mem_rdy) begin
            sp_spec_q <= is_call ? sp_dec : sp_inc;
            if (!is_call) begin
              case (idx_q)
                2'd0:    pop_ip_q <= mem_rdata;
                2'd1:    pop_cs_q <= mem_rdata;
                default: pop_fl_q <= mem_rdata;
              endcase
            end
            idx_q <= idx_q + 2'd1;
            if (last_word) st_q <= ST_FIN;
          end
        end
        default: begin
          done        <= 1'b1;
          nmi_unblock <= (op_q == OP_IRET);
          if (ip_over) begin
            fault   <= 1'b1;
            ip_out  <= ip_q;
            cs_out  <= cs_q;
            cs_base <= orig_base;
            sp_out  <= sp_orig_q;
          end else begin
            ip_out  <= new_ip;
            cs_out  <= new_cs;
            cs_base <= new_base;
            sp_out  <= is_ret_imm ? sp_adj : sp_spec_q;
            if (op_q == OP_IRET) begin
              flags_out <= pop_fl_q;
              flags_wr  <= 1'b1;
            end
          end
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  // The starting IP is only compared for its base; its limit result is unused.
  logic unused_orig;
  assign unused_orig = orig_over;

endmodule

// File: rtl/rm_stack_seq_chk.sv
module rm_stack_seq_chk #(
  parameter int WORD = 16,
  parameter int SPW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic            mem_rdy,
  input logic            mem_we,
  input logic [SPW-1:0]  mem_addr,
  input logic [WORD-1:0] mem_wdata,
  input logic            done,
  input logic            fault,
  input logic            flags_wr,
  input logic            nmi_unblock
);
  a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_port_quiet_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  a_r7_fault_with_done: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  a_r4_flags_clean_end: assert property (@(posedge clk) disable iff (rst)
    flags_wr |-> (done && !fault && nmi_unblock));

  a_r4_nmi_at_end: assert property (@(posedge clk) disable iff (rst)
    nmi_unblock |-> done);
endmodule

bind rm_stack_seq rm_stack_seq_chk #(.WORD(WORD), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .fault(fault),
  .flags_wr(flags_wr), .nmi_unblock(nmi_unblock)
);

// File: tb/tb_rm_stack_seq.sv
module tb_rm_stack_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] ip_in = '0, cs_in = '0, imm_adj = '0, tgt_ip = '0, tgt_cs = '0, cs_limit = '0;
  logic [31:0] sp_in = '0;
  logic        stk32 = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;
  logic [15:0] ip_out, cs_out, flags_out;
  logic [19:0] cs_base;
  logic [31:0] sp_out;
  logic        flags_wr, nmi_unblock, done, fault;

  rm_stack_seq dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ip_in(ip_in), .cs_in(cs_in),
    .sp_in(sp_in), .stk32(stk32), .imm_adj(imm_adj), .tgt_ip(tgt_ip), .tgt_cs(tgt_cs),
    .cs_limit(cs_limit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .ip_out(ip_out),
    .cs_out(cs_out), .cs_base(cs_base), .sp_out(sp_out), .flags_out(flags_out),
    .flags_wr(flags_wr), .nmi_unblock(nmi_unblock), .done(done), .fault(fault)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [15:0] data;
  } acc_t;

  acc_t        exp_q[$];
  logic [15:0] mem [int unsigned];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          lat     = 0;
  int          wcnt    = 0;
  int          req_cycles = 0;
  bit          expect_done = 1'b0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'hA5A5;
  endfunction

  function automatic logic [31:0] stepf(input logic [31:0] s, input int d, input bit big);
    logic [15:0] lo;
    if (big) return s + 32'(d);
    lo = s[15:0] + 16'(d);
    return {s[31:16], lo};
  endfunction

  function automatic logic [31:0] addrf(input logic [31:0] s, input bit big);
    return big ? s : {16'h0000, s[15:0]};
  endfunction

  // Memory responder and per-access comparison against the model (R8).
  always @(negedge clk) begin
    mem_rdy = 1'b0;
    if (!rst && mem_req) begin
      req_cycles++;
      if (wcnt == 0) begin
        mem_rdy = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected access", mem_addr, 32'h0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, "R8 access direction", 32'(mem_we), 32'(e.we));
          check(mem_addr == e.addr, "R6 access address", mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.data, "R1/R2 pushed word", 32'(mem_wdata), 32'(e.data));
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else        mem_rdata = mread(mem_addr);
        wcnt = lat;
      end else begin
        wcnt--;
      end
    end else begin
      wcnt = lat;
    end
  end

  // Every clock: done only inside an operation window (R9).
  always @(negedge clk) begin
    if (!rst && done && !expect_done)
      check(1'b0, "R9 stray done", 32'(done), 32'h0);
  end

  task automatic run_op(input int opc, input logic [15:0] ip, input logic [15:0] cs,
                        input logic [31:0] sp, input bit big, input logic [15:0] imm,
                        input logic [15:0] tip, input logic [15:0] tcs, input logic [15:0] lim,
                        input int lat_v, input bit poke, input string tag);
    logic [31:0] s;
    logic [15:0] vals [3];
    logic [15:0] n_ip, n_cs, e_ip, e_cs;
    logic [31:0] e_sp;
    logic [19:0] e_base;
    bit          flt;
    int          nw;
    int          waited;
    acc_t        a;
    s = sp;
    exp_q.delete();
    vals[0] = '0; vals[1] = '0; vals[2] = '0;
    if (opc <= 1) begin
      if (opc == 1) begin
        s = stepf(s, -2, big);
        a.we = 1'b1; a.addr = addrf(s, big); a.data = cs; exp_q.push_back(a);
      end
      s = stepf(s, -2, big);
      a.we = 1'b1; a.addr = addrf(s, big); a.data = ip; exp_q.push_back(a);
    end else begin
      nw = (opc == 2) ? 1 : (opc == 3) ? 2 : 3;
      for (int k = 0; k < nw; k++) begin
        a.we = 1'b0; a.addr = addrf(s, big); a.data = mread(a.addr); exp_q.push_back(a);
        vals[k] = a.data;
        s = stepf(s, 2, big);
      end
    end
    n_ip = (opc <= 1) ? tip : vals[0];
    n_cs = (opc == 1) ? tcs : (opc >= 3) ? vals[1] : cs;
    flt  = (n_ip > lim);
    if (opc == 2 || opc == 3) s = stepf(s, int'(imm), big);
    e_ip = flt ? ip : n_ip;
    e_cs = flt ? cs : n_cs;
    e_sp = flt ? sp : s;
    e_base = {e_cs, 4'h0};

    lat = lat_v;
    wcnt = lat_v;
    @(negedge clk);
    op = 3'(opc); ip_in = ip; cs_in = cs; sp_in = sp; stk32 = big; imm_adj = imm;
    tgt_ip = tip; tgt_cs = tcs; cs_limit = lim; start = 1'b1;
    expect_done = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a second start mid-operation with different inputs must be ignored.
      op = 3'd1; ip_in = 16'hDEAD; sp_in = 32'h0000_0800; tgt_ip = 16'h0001; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, {tag, " R9 done seen"}, 32'(done), 32'h1);
    check(fault == flt, {tag, " R7 fault"}, 32'(fault), 32'(flt));
    check(ip_out == e_ip, {tag, " R1/R3/R7 ip"}, 32'(ip_out), 32'(e_ip));
    check(cs_out == e_cs, {tag, " R2/R3/R7 cs"}, 32'(cs_out), 32'(e_cs));
    check(cs_base == e_base, {tag, " R2/R3 cs base"}, 32'(cs_base), 32'(e_base));
    check(sp_out == e_sp, {tag, " R5/R6/R7 sp"}, sp_out, e_sp);
    check(nmi_unblock == (opc == 4), {tag, " R4 nmi unblock"}, 32'(nmi_unblock), 32'(opc == 4));
    check(flags_wr == (opc == 4 && !flt), {tag, " R4 flags write"}, 32'(flags_wr), 32'(opc == 4 && !flt));
    if (opc == 4 && !flt)
      check(flags_out == vals[2], {tag, " R4 flags value"}, 32'(flags_out), 32'(vals[2]));
    check(mem_req == 1'b0, {tag, " R9 port idle at done"}, 32'(mem_req), 32'h0);
    check(exp_q.size() == 0, {tag, " R8 all accesses made"}, 32'(exp_q.size()), 32'h0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 done one cycle"}, 32'(done), 32'h0);
    expect_done = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(mem_req == 1'b0 && done == 1'b0 && fault == 1'b0, "R10 idle flags", {29'h0, mem_req, done, fault}, 32'h0);
    check(flags_wr == 1'b0 && nmi_unblock == 1'b0, "R10 pulses low", {30'h0, flags_wr, nmi_unblock}, 32'h0);
    check(ip_out == 0 && cs_out == 0 && sp_out == 0 && cs_base == 0, "R10 state zero", sp_out, 32'h0);

    // R1 near call, 16-bit stack, immediate ignored (R5)
    run_op(0, 16'h0105, 16'h1000, 32'h0000_0100, 1'b0, 16'h0040, 16'h0200, 16'h3333, 16'hFFFF, 0, 1'b0, "near-call");
    // R2 far call, 32-bit stack
    run_op(1, 16'h0222, 16'h1100, 32'h0002_0000, 1'b1, 16'h0000, 16'h0010, 16'h4321, 16'hFFFF, 1, 1'b0, "far-call");
    // R6 push wraps in the low half
    run_op(0, 16'h0333, 16'h0001, 32'hABCD_0000, 1'b0, 16'h0000, 16'h0044, 16'h0000, 16'hFFFF, 2, 1'b0, "push-wrap");
    // R3/R5 near return, pop then immediate wraps in the low half
    mem[32'h0000_FFFE] = 16'h0777;
    run_op(2, 16'h0001, 16'h0500, 32'h1234_FFFE, 1'b0, 16'h0004, 16'h0000, 16'h0000, 16'hFFFF, 0, 1'b0, "near-ret-wrap");
    // R3/R5 far return, 32-bit stack with immediate
    mem[32'h0001_0000] = 16'h0300; mem[32'h0001_0002] = 16'h2000;
    run_op(3, 16'h0001, 16'h0500, 32'h0001_0000, 1'b1, 16'h0006, 16'h0000, 16'h0000, 16'hFFFF, 1, 1'b0, "far-ret");
    // R4 interrupt return, immediate ignored
    mem[32'h0500] = 16'h0010; mem[32'h0502] = 16'hF000; mem[32'h0504] = 16'h0246;
    run_op(4, 16'h0001, 16'h0500, 32'h0000_0500, 1'b0, 16'h0008, 16'h0000, 16'h0000, 16'hFFFF, 2, 1'b0, "iret");
    // R7 far return over the limit
    mem[32'h0600] = 16'h8000; mem[32'h0602] = 16'h6000;
    run_op(3, 16'h0042, 16'h0700, 32'h0000_0600, 1'b0, 16'h0002, 16'h0000, 16'h0000, 16'h7FFF, 0, 1'b0, "far-ret-fault");
    // R7 near call over the limit, after the push
    run_op(0, 16'h0050, 16'h0900, 32'h0000_0400, 1'b0, 16'h0000, 16'h9000, 16'h0000, 16'h8FFF, 1, 1'b0, "near-call-fault");
    // R4/R7 faulting interrupt return still unblocks NMI
    mem[32'h0700] = 16'hFFF0; mem[32'h0702] = 16'h1234; mem[32'h0704] = 16'h0002;
    run_op(4, 16'h0060, 16'h0A00, 32'h0000_0700, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h00FF, 0, 1'b0, "iret-fault");
    // R7 IP equal to the limit does not fault
    mem[32'h0800] = 16'h1FFF;
    run_op(2, 16'h0001, 16'h0B00, 32'h0000_0800, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h1FFF, 0, 1'b0, "ip-at-limit");
    // R9 start while busy is ignored
    mem[32'h0900] = 16'h0123; mem[32'h0902] = 16'h0C00;
    run_op(3, 16'h0001, 16'h0B00, 32'h0000_0900, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 2, 1'b1, "busy-start");

    // R9 invalid operation code is ignored: no access, no done
    req_cycles = 0;
    @(negedge clk);
    op = 3'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(req_cycles == 0, "R9 invalid op no access", 32'(req_cycles), 32'h0);
    check(done == 1'b0, "R9 invalid op no done", 32'(done), 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule